// File: doc/BRIEF.md
# Packed BCD to Binary Converter

This block turns packed decimal numbers into unsigned binary. A wide input word is split into independent lanes. Each lane carries a fixed number of decimal digits, four bits per digit, with the most significant digit in the top nybble of the lane. Each lane comes out as one unsigned binary value of the same width.

The conversion does not handle one digit after another. It merges fields whose width doubles at each level. At the first level every 8-bit field becomes the upper digit times ten plus the lower digit. At the second level every 16-bit field becomes its upper half times one hundred plus its lower half. At the third level every 32-bit field becomes its upper half times ten thousand plus its lower half. Each level is one register stage. A new word can enter on every clock, and its result appears three cycles later.

A lane that holds any nybble above nine raises its own error flag. The flag appears in the same cycle as the lane's result, and the binary value of that lane is then meaningless.

Top module: `bcd_pack_to_bin`

## Requirements
- R1: `out_valid` is high exactly three clock cycles after the cycle in which `in_valid` was sampled high. It is low otherwise.
- R2: For a lane whose eight nybbles are all 0 to 9, the output lane equals the decimal number those digits spell. The digit in bits [31:28] of the lane has the most weight and the digit in bits [3:0] has the least.
- R3: Lane i occupies bits [32i+31:32i] of both `in_bcd` and `out_bin`, and the flag for lane i is bit i of `out_err`. The contents of one lane never affect the result or the flag of another lane.
- R4: When `out_valid` is high, bit i of `out_err` is 1 exactly when at least one nybble of input lane i was above 9.
- R5: A lane without an error flag never produces a value above 99999999.
- R6: A lane of all zero digits converts to 0, and a lane of all nine digits (0x99999999) converts to 99999999.
- R7: While `rst_n` is low at a clock edge, the following cycle shows `out_valid`, `out_bin` and `out_err` all zero.
- R8: Inputs presented on consecutive cycles produce results on consecutive cycles, in input order, with no gap.
- R9: `out_err` is all zero whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks `in_bcd` as carrying a word to convert |
| in_bcd | input | 128 | Four lanes of eight packed decimal digits |
| out_valid | output | 1 | Marks `out_bin` and `out_err` as a result |
| out_bin | output | 128 | Four 32-bit unsigned binary lane results |
| out_err | output | 4 | One flag per lane for a nybble above nine |

## Verification
On every cycle the assertions check four things. The valid pipeline has a fixed latency. The error flag of each lane matches a per-lane nybble scan of the input from three cycles earlier. A lane without an error never goes above the eight-digit decimal limit. The flags are quiet whenever no result is present.

The numeric correctness of each lane can only be shown by the bench's scenarios. These are a digit-by-digit reference on random digits, the all-zero and all-nine edges, lanes mixing good and bad digits in different positions, and back-to-back and gapped traffic.

// File: rtl/bcd2bin_pkg.sv
// Package: shared helpers for the packed decimal converter.
// Assumes the powers requested fit in 32 bits (exponent at most 9).
package bcd2bin_pkg;

    // Power of ten used as the multiplier of a merge level.
    function automatic int unsigned pow10(input int unsigned exp_n);
        int unsigned acc;
        acc = 1;
        for (int unsigned i = 0; i < exp_n; i++) begin
            acc = acc * 10;
        end
        return acc;
    endfunction

endpackage

// File: rtl/bcd_nybble_check.sv
// Module: bcd_nybble_check
// Flags each lane that holds any nybble above nine. This is purely combinational.
// Assumes lanes are DIGITS nybbles wide and packed from bit 0 upward.
module bcd_nybble_check #(
    parameter int LANES  = 4,
    parameter int DIGITS = 8
) (
    input  logic [LANES*DIGITS*4-1:0] bcd,
    output logic [LANES-1:0]          bad
);
    localparam int LANE_W = DIGITS * 4;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DIGITS-1:0] digit_bad;
        for (genvar d = 0; d < DIGITS; d++) begin : g_digit
            // Compare one nybble against nine.
            assign digit_bad[d] = bcd[l*LANE_W + d*4 +: 4] > 4'd9;
        end
        // The lane is bad if any of its digits is bad.
        assign bad[l] = |digit_bad;
    end
endmodule

// File: rtl/bcd_merge_stage.sv
// Module: bcd_merge_stage
// One registered merge level. Every FIELD_W-bit field becomes
// (upper half * MULT) + lower half, and the sideband error flags move along with the data.
// Assumes the result of each field fits in FIELD_W bits for legal digits.
module bcd_merge_stage #(
    parameter int          BUS_W   = 128,
    parameter int          FIELD_W = 8,
    parameter int unsigned MULT    = 10,
    parameter int          ERR_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [BUS_W-1:0] in_data,
    input  logic [ERR_W-1:0] in_err,
    output logic             out_valid,
    output logic [BUS_W-1:0] out_data,
    output logic [ERR_W-1:0] out_err
);
    localparam int HALF_W   = FIELD_W / 2;
    localparam int N_FIELDS = BUS_W / FIELD_W;
    localparam logic [FIELD_W-1:0] MULT_C = FIELD_W'(MULT);

    logic [BUS_W-1:0] merged;

    for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
        logic [FIELD_W-1:0] hi_ext;
        logic [FIELD_W-1:0] lo_ext;
        // Move the upper half down to the low bits and zero-extend the lower half.
        assign hi_ext = FIELD_W'(in_data[f*FIELD_W + HALF_W +: HALF_W]);
        assign lo_ext = FIELD_W'(in_data[f*FIELD_W +: HALF_W]);
        // Multiply the upper half by the constant and add the lower half.
        assign merged[f*FIELD_W +: FIELD_W] = hi_ext * MULT_C + lo_ext;
    end

    // Pipeline register. Flags are kept only while the data is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_err   <= '0;
        end else begin
            out_valid <= in_valid;
            out_data  <= merged;
            out_err   <= in_valid ? in_err : '0;
        end
    end
endmodule

// File: rtl/bcd_pack_to_bin.sv
// Module: bcd_pack_to_bin (top)
// Converts LANES lanes of DIGITS packed decimal digits into binary. It uses
// log2(DIGITS) merge levels, each one register deep.
// Assumes DIGITS is a power of two and 10^DIGITS - 1 fits in the lane.
module bcd_pack_to_bin #(
    parameter int LANES  = 4,
    parameter int DIGITS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [LANES*DIGITS*4-1:0] in_bcd,
    output logic                      out_valid,
    output logic [LANES*DIGITS*4-1:0] out_bin,
    output logic [LANES-1:0]          out_err
);
    localparam int LANE_W = DIGITS * 4;
    localparam int BUS_W  = LANES * LANE_W;
    localparam int LEVELS = $clog2(DIGITS);

    logic [BUS_W-1:0] lvl_data  [0:LEVELS];
    logic             lvl_valid [0:LEVELS];
    logic [LANES-1:0] lvl_err   [0:LEVELS];
    logic [LANES-1:0] lane_bad;

    // Scan the incoming digits for values above nine.
    bcd_nybble_check #(.LANES(LANES), .DIGITS(DIGITS)) chk_u (
        .bcd (in_bcd),
        .bad (lane_bad)
    );

    // Feed the first level.
    assign lvl_data[0]  = in_bcd;
    assign lvl_valid[0] = in_valid;
    assign lvl_err[0]   = lane_bad;

    for (genvar k = 0; k < LEVELS; k++) begin : g_level
        bcd_merge_stage #(
            .BUS_W   (BUS_W),
            .FIELD_W (8 << k),
            .MULT    (bcd2bin_pkg::pow10(1 << k)),
            .ERR_W   (LANES)
        ) stage_u (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (lvl_valid[k]),
            .in_data   (lvl_data[k]),
            .in_err    (lvl_err[k]),
            .out_valid (lvl_valid[k+1]),
            .out_data  (lvl_data[k+1]),
            .out_err   (lvl_err[k+1])
        );
    end

    // Drive the outputs from the last level.
    assign out_valid = lvl_valid[LEVELS];
    assign out_bin   = lvl_data[LEVELS];
    assign out_err   = lvl_err[LEVELS];
endmodule

// File: rtl/bcd_pack_to_bin_chk.sv
// Module: bcd_pack_to_bin_chk
// Property checker bound to the top. It keeps a small model of valid and
// per-lane digit legality, delayed by the number of merge levels.
module bcd_pack_to_bin_chk #(
    parameter int LANES  = 4,
    parameter int DIGITS = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [LANES*DIGITS*4-1:0] in_bcd,
    input logic                      out_valid,
    input logic [LANES*DIGITS*4-1:0] out_bin,
    input logic [LANES-1:0]          out_err
);
    localparam int LANE_W = DIGITS * 4;
    localparam int LEVELS = $clog2(DIGITS);
    localparam logic [LANE_W-1:0] LANE_MAX = LANE_W'(bcd2bin_pkg::pow10(DIGITS) - 1);

    logic             m_valid [0:LEVELS-1];
    logic [LANES-1:0] m_bad   [0:LEVELS-1];
    logic [LANES-1:0] scan_bad;

    // Independent scan of each lane: does any digit exceed nine?
    always_comb begin
        scan_bad = '0;
        for (int l = 0; l < LANES; l++) begin
            for (int d = 0; d < DIGITS; d++) begin
                if (in_bcd[l*LANE_W + d*4 +: 4] >= 4'd10) scan_bad[l] = 1'b1;
            end
        end
    end

    // Delay line that models the latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LEVELS; i++) begin
                m_valid[i] <= 1'b0;
                m_bad[i]   <= '0;
            end
        end else begin
            m_valid[0] <= in_valid;
            m_bad[0]   <= scan_bad;
            for (int i = 1; i < LEVELS; i++) begin
                m_valid[i] <= m_valid[i-1];
                m_bad[i]   <= m_bad[i-1];
            end
        end
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == m_valid[LEVELS-1]);

    assert_err_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_err == m_bad[LEVELS-1]);

    assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_err == '0);

    for (genvar l = 0; l < LANES; l++) begin : g_ovf
        assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_err[l]) |-> out_bin[l*LANE_W +: LANE_W] <= LANE_MAX);
    end
endmodule

bind bcd_pack_to_bin bcd_pack_to_bin_chk #(.LANES(LANES), .DIGITS(DIGITS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_bcd    (in_bcd),
    .out_valid (out_valid),
    .out_bin   (out_bin),
    .out_err   (out_err)
);

// File: tb/bcd_pack_to_bin_tb_top.sv
`timescale 1ns/1ps
// Bench: random and directed decimal words, checked lane by lane against a
// reference that accumulates one digit at a time.
module bcd_pack_to_bin_tb_top;
    localparam int LANES = 4;
    localparam int DIGITS = 8;
    localparam int LANE_W = DIGITS * 4;
    localparam int BUS_W = LANES * LANE_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [BUS_W-1:0] in_bcd = '0;
    logic             out_valid;
    logic [BUS_W-1:0] out_bin;
    logic [LANES-1:0] out_err;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic             h_valid [0:2];
    logic [BUS_W-1:0] h_data  [0:2];

    bcd_pack_to_bin #(.LANES(LANES), .DIGITS(DIGITS)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bcd(in_bcd),
        .out_valid(out_valid), .out_bin(out_bin), .out_err(out_err)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Reference: lane value built digit by digit from the most significant nybble.
    function automatic logic [31:0] ref_value(input logic [LANE_W-1:0] lane);
        logic [31:0] v = 0;
        for (int d = DIGITS - 1; d >= 0; d--) v = v * 10 + 32'(lane[d*4 +: 4]);
        return v;
    endfunction

    function automatic logic ref_bad(input logic [LANE_W-1:0] lane);
        for (int d = 0; d < DIGITS; d++) if (lane[d*4 +: 4] > 9) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One negedge: check the word driven three steps ago, then drive the next.
    task automatic step(input logic v, input logic [BUS_W-1:0] d);
        @(negedge clk);
        check("R1 out_valid", 32'(out_valid), 32'(h_valid[2]));
        if (h_valid[2]) begin
            for (int l = 0; l < LANES; l++) begin
                logic [LANE_W-1:0] lane = h_data[2][l*LANE_W +: LANE_W];
                logic eb = ref_bad(lane);
                check("R4 R3 lane flag", 32'(out_err[l]), 32'(eb));
                if (!eb) begin
                    check("R2 R3 R8 lane value", out_bin[l*LANE_W +: LANE_W], ref_value(lane));
                    check("R5 range", 32'(out_bin[l*LANE_W +: LANE_W] <= 32'd99999999), 32'd1);
                end
            end
        end else begin
            check("R9 quiet flags", 32'(out_err), 32'd0);
        end
        h_valid[2] = h_valid[1]; h_data[2] = h_data[1];
        h_valid[1] = h_valid[0]; h_data[1] = h_data[0];
        h_valid[0] = v;          h_data[0] = d;
        in_valid = v;
        in_bcd   = d;
    endtask

    function automatic logic [LANE_W-1:0] rand_lane();
        logic [LANE_W-1:0] x;
        for (int d = 0; d < DIGITS; d++) x[d*4 +: 4] = 4'($urandom % 10);
        if ($urandom % 8 == 0) x[($urandom % DIGITS)*4 +: 4] = 4'(10 + $urandom % 6);
        return x;
    endfunction

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 3; i++) begin h_valid[i] = 1'b0; h_data[i] = '0; end
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_bcd = {BUS_W{1'b1}};
        repeat (4) @(negedge clk);
        // R7: the reset state is clear even with a valid input held present.
        check("R7 out_valid reset", 32'(out_valid), 32'd0);
        check("R7 out_bin reset", 32'(|out_bin), 32'd0);
        check("R7 out_err reset", 32'(out_err), 32'd0);
        in_valid = 1'b0;
        in_bcd = '0;
        rst_n = 1'b1;
        // R6 edges: all zero, then all nine, back to back.
        step(1'b1, '0);
        step(1'b1, {LANES{32'h9999_9999}});
        // R3: mixed lanes, one of them with a bad top digit.
        step(1'b1, {32'hA000_0001, 32'h1234_5678, 32'h9999_9999, 32'h0000_0000});
        // R4: a bad lowest digit in lane 0 only.
        step(1'b1, {32'h8765_4321, 32'h0000_0010, 32'h5000_0005, 32'h0000_000F});
        step(1'b0, {LANES{32'hFFFF_FFFF}});
        step(1'b0, '0);
        step(1'b1, {32'h0000_0009, 32'h9000_0000, 32'h0909_0909, 32'h1000_0000});
        // Random traffic with gaps.
        for (int n = 0; n < 400; n++) begin
            logic [BUS_W-1:0] w;
            for (int l = 0; l < LANES; l++) w[l*LANE_W +: LANE_W] = rand_lane();
            step(($urandom % 4) != 0, w);
        end
        repeat (5) step(1'b0, '0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule